// File: doc/BRIEF.md
# Dual-Mode Edge-Programmable PWM Generator

This block produces six pulse-width-modulated outputs from one shared time base. A counter advances once per prescaled clock tick and is compared against seven match values. A match can raise an interrupt flag, send the counter back to zero, or halt it. Match 0 normally closes the period by returning the counter to zero, and that moment is the period boundary.

Each output runs in one of two modes. In single-edge mode the output rises at the boundary and falls on its own match. In double-edge mode the output rises on the match one below its own and falls on its own match. Because the edges come from match values, period and pulse width are each any number of counts. Software writes new match values into shadow copies. It then marks them with a latch bit, and they take effect together at the next boundary, so no period ever runs with half-updated edges.

Software reaches the block through a flat register port with a write strobe, an address and a combinational read. The same port carries all configuration and status.

Top module: `pwm_unit`

## Requirements
- R1: While run (CTRL address 0, bit 0) is 1 and hold (CTRL bit 1) is 0, the counter advances by one every PRESC+1 clocks, where PRESC is the value at address 1. The counter value reads back at address 2.
- R2: When the counter equals an active match value on a tick and that match's reset action is enabled, the counter returns to 0. With reset enabled on match 0, the counter cycles through 0..MR0, so the period is MR0+1 ticks.
- R3: A single-edge output n (1..6) is high for MRn+1 ticks of each period. If MRn is at least MR0 it stays high for the whole period. When the boundary and its own match coincide, the rising edge wins.
- R4: A double-edge output n rises on the tick of match n-1 and falls on the tick of match n. If the two coincide, the falling edge wins. Address 4 bit n-1 set to 1 selects double-edge mode for output n. Bit 0 has no effect, so output 1 is always single-edge.
- R5: A write to address 8+m sets shadow match m, and reading that address returns the shadow value. Writing 1 to bit m at address 6 marks shadow m pending. A pending value becomes active at the next period boundary, or at once while hold is 1. Address 6 reads 1 for bit m while m is still pending.
- R6: On a match with its interrupt action enabled, flag m (address 7, bit m) is set. Writing 1 to a flag bit clears it, and a new set in the same cycle wins. irq_o is the OR of all flags.
- R7: A match with its stop action enabled clears run, and the counter keeps the matched value. Match actions sit at address 3, three bits per match m: bit 3m is interrupt, bit 3m+1 is reset, bit 3m+2 is stop.
- R8: Address 5 bit n-1 enables output n. A disabled output is driven low.
- R9: While hold is 1, the counter and prescaler sit at 0, single-edge outputs are high and double-edge outputs are low.
- R10: After reset, every register is 0, all outputs are low and irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pwm_o | output | 6 | PWM outputs; bit n-1 is output n |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench measures each output's high time over exactly one period and aims at the edge collisions. One case makes a single-edge match equal to the period end; a design that let the falling edge win there would drop to zero duty. Another makes the two double-edge matches equal; a design that let the rising edge win would show a constant high. A third puts the rising match after the falling one, and a wrong wrap would lose the pulse that spans the boundary. The bench also changes a shadow value without latching it, and a design that applied it early would change the duty at once. A stopped counter must keep its pending latch, a prescaler off by one would stretch the pulses, and a flag clear that lost to a stale set would leave irq_o stuck.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int ADDR_W   = 4;
    localparam int DATA_W   = 32;

    localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
    localparam logic [ADDR_W-1:0] A_PRESC  = 4'd1;
    localparam logic [ADDR_W-1:0] A_COUNT  = 4'd2;
    localparam logic [ADDR_W-1:0] A_MACT   = 4'd3;
    localparam logic [ADDR_W-1:0] A_MODE   = 4'd4;
    localparam logic [ADDR_W-1:0] A_OEN    = 4'd5;
    localparam logic [ADDR_W-1:0] A_LATCH  = 4'd6;
    localparam logic [ADDR_W-1:0] A_FLAGS  = 4'd7;
    localparam int                A_MATCH0 = 8;

    // per-match action bits, packed as {stop, reset, interrupt}
    typedef struct packed {
        logic stop;
        logic rst;
        logic irq;
    } mact_t;
endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [CNT_W-1:0] limit,
    output logic             tick
);
    typedef struct packed {
        logic [CNT_W-1:0] pc;
    } ps_state_t;

    ps_state_t s_q, s_d;

    always_comb begin
        s_d  = s_q;
        tick = en && !clr && (s_q.pc >= limit);
        if (clr) begin
            s_d.pc = '0;
        end else if (en) begin
            s_d.pc = tick ? '0 : s_q.pc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R1
    tick_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (s_q.pc == '0));
endmodule

// File: rtl/pwm_match_bank.sv
module pwm_match_bank #(
    parameter int NUM_MATCH = 7,
    parameter int CNT_W     = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_MATCH-1:0]              wr_en,
    input  logic [CNT_W-1:0]                  wdata,
    input  logic [NUM_MATCH-1:0]              latch_set,
    input  logic                              xfer,
    input  logic                              tick,
    input  logic [CNT_W-1:0]                  tc,
    output logic [NUM_MATCH-1:0]              hit,
    output logic [NUM_MATCH-1:0][CNT_W-1:0]   shadow_o,
    output logic [NUM_MATCH-1:0]              pend_o
);
    typedef struct packed {
        logic [NUM_MATCH-1:0][CNT_W-1:0] shadow;
        logic [NUM_MATCH-1:0][CNT_W-1:0] act;
        logic [NUM_MATCH-1:0]            pend;
    } mb_state_t;

    mb_state_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        for (int m = 0; m < NUM_MATCH; m++) begin
            if (wr_en[m]) s_d.shadow[m] = wdata;
            if (xfer && s_q.pend[m]) s_d.act[m] = s_q.shadow[m];
            hit[m] = tick && (s_q.act[m] == tc);
        end
        s_d.pend = (s_q.pend & ~{NUM_MATCH{xfer}}) | latch_set;
    end

    assign shadow_o = s_q.shadow;
    assign pend_o   = s_q.pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R5
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |=> $stable(s_q.act));
endmodule

// File: rtl/pwm_edge_ch.sv
module pwm_edge_ch (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic boundary,
    input  logic set_hit,
    input  logic clr_hit,
    input  logic dbl,
    input  logic en,
    output logic pwm_o
);
    typedef struct packed {
        logic lvl;
    } ch_state_t;

    ch_state_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (hold) begin
            s_d.lvl = !dbl;
        end else if (dbl) begin
            if (clr_hit)      s_d.lvl = 1'b0;
            else if (set_hit) s_d.lvl = 1'b1;
        end else begin
            if (boundary)     s_d.lvl = 1'b1;
            else if (clr_hit) s_d.lvl = 1'b0;
        end
    end

    assign pwm_o = en & s_q.lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R4
    dbl_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbl && clr_hit) |=> !s_q.lvl);

    // R3
    sgl_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbl && boundary && !hold) |=> s_q.lvl);
endmodule

// File: rtl/pwm_unit.sv
module pwm_unit
    import pwm_pkg::*;
#(
    parameter int NUM_OUT = 6,
    parameter int CNT_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NUM_OUT-1:0] pwm_o,
    output logic              irq_o
);
    localparam int NUM_MATCH = NUM_OUT + 1;

    typedef struct packed {
        logic                     run;
        logic                     hold;
        logic [CNT_W-1:0]         presc;
        mact_t [NUM_MATCH-1:0]    mact;
        logic [NUM_OUT-1:0]       dbl;
        logic [NUM_OUT-1:0]       oen;
        logic [NUM_MATCH-1:0]     flags;
        logic [CNT_W-1:0]         tc;
    } top_state_t;

    top_state_t s_q, s_d;

    logic                            tick;
    logic [NUM_MATCH-1:0]            hit;
    logic [NUM_MATCH-1:0][CNT_W-1:0] shadow;
    logic [NUM_MATCH-1:0]            pend;
    logic [NUM_MATCH-1:0]            mwr;
    logic [NUM_MATCH-1:0]            latch_set;
    logic [NUM_MATCH-1:0]            irq_mask, rst_mask, stop_mask;
    logic                            rst_any, stop_any, boundary, xfer;
    logic                            wdata_unused;

    assign wdata_unused = ^reg_wdata;

    always_comb begin
        for (int m = 0; m < NUM_MATCH; m++) begin
            irq_mask[m]  = s_q.mact[m].irq;
            rst_mask[m]  = s_q.mact[m].rst;
            stop_mask[m] = s_q.mact[m].stop;
            mwr[m]       = reg_we && (reg_addr == ADDR_W'(A_MATCH0 + m));
        end
        latch_set = (reg_we && reg_addr == A_LATCH) ? reg_wdata[NUM_MATCH-1:0] : '0;
        rst_any   = |(hit & rst_mask);
        stop_any  = |(hit & stop_mask);
        boundary  = tick && rst_any;
        xfer      = boundary || s_q.hold;
    end

    pwm_prescale #(.CNT_W(CNT_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (s_q.hold),
        .en    (s_q.run),
        .limit (s_q.presc),
        .tick  (tick)
    );

    pwm_match_bank #(.NUM_MATCH(NUM_MATCH), .CNT_W(CNT_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (mwr),
        .wdata     (reg_wdata[CNT_W-1:0]),
        .latch_set (latch_set),
        .xfer      (xfer),
        .tick      (tick),
        .tc        (s_q.tc),
        .hit       (hit),
        .shadow_o  (shadow),
        .pend_o    (pend)
    );

    // next-state computation for configuration, flags and counter
    always_comb begin
        s_d = s_q;
        if (reg_we) begin
            case (reg_addr)
                A_CTRL: begin
                    s_d.run  = reg_wdata[0];
                    s_d.hold = reg_wdata[1];
                end
                A_PRESC: s_d.presc = reg_wdata[CNT_W-1:0];
                A_MACT: begin
                    for (int m = 0; m < NUM_MATCH; m++)
                        s_d.mact[m] = reg_wdata[3*m +: 3];
                end
                A_MODE:  s_d.dbl   = reg_wdata[NUM_OUT-1:0];
                A_OEN:   s_d.oen   = reg_wdata[NUM_OUT-1:0];
                A_FLAGS: s_d.flags = s_q.flags & ~reg_wdata[NUM_MATCH-1:0];
                default: ;
            endcase
        end
        s_d.flags = s_d.flags | (hit & irq_mask);
        if (stop_any) s_d.run = 1'b0;
        if (s_q.hold) begin
            s_d.tc = '0;
        end else if (tick) begin
            if (rst_any)       s_d.tc = '0;
            else if (stop_any) s_d.tc = s_q.tc;
            else               s_d.tc = s_q.tc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL:  reg_rdata = DATA_W'({s_q.hold, s_q.run});
            A_PRESC: reg_rdata = DATA_W'(s_q.presc);
            A_COUNT: reg_rdata = DATA_W'(s_q.tc);
            A_MACT:  reg_rdata = DATA_W'(s_q.mact);
            A_MODE:  reg_rdata = DATA_W'(s_q.dbl);
            A_OEN:   reg_rdata = DATA_W'(s_q.oen);
            A_LATCH: reg_rdata = DATA_W'(pend);
            A_FLAGS: reg_rdata = DATA_W'(s_q.flags);
            default: begin
                for (int m = 0; m < NUM_MATCH; m++)
                    if (reg_addr == ADDR_W'(A_MATCH0 + m))
                        reg_rdata = DATA_W'(shadow[m]);
            end
        endcase
    end

    assign irq_o = |s_q.flags;

    // output channels: channel 0 has no lower neighbour, so it is single-edge only
    for (genvar n = 0; n < NUM_OUT; n++) begin : g_ch
        logic dbl_eff;
        if (n == 0) begin : g_first
            assign dbl_eff = 1'b0;
        end else begin : g_rest
            assign dbl_eff = s_q.dbl[n];
        end
        pwm_edge_ch u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .hold     (s_q.hold),
            .boundary (boundary),
            .set_hit  (hit[n]),
            .clr_hit  (hit[n+1]),
            .dbl      (dbl_eff),
            .en       (s_q.oen[n]),
            .pwm_o    (pwm_o[n])
        );
    end

    // R1
    count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !s_q.hold) |=> $stable(s_q.tc));

    // R2
    period_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> (s_q.tc == '0));

    // R7
    stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_any |=> !s_q.run);

    // R6
    for (genvar m = 0; m < NUM_MATCH; m++) begin : g_flag_chk
        flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[m] && s_q.mact[m].irq) |=> s_q.flags[m]);
    end
endmodule

// File: tb/tb_pwm_unit.sv
module tb_pwm_unit;
    import pwm_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [5:0]  pwm_o;
    logic        irq_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    pwm_unit dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pwm_o     (pwm_o),
        .irq_o     (irq_o)
    );

    // mr: match values, MR6 first; dbl: mode bits; ex: high ticks per period, output 6 first
    typedef struct packed {
        logic [6:0][7:0] mr;
        logic [5:0]      dbl;
        logic [5:0][7:0] ex;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{mr: {8'd8, 8'd5, 8'd12, 8'd9, 8'd3, 8'd0, 8'd9},
          dbl: 6'b000000, ex: {8'd9, 8'd6, 8'd10, 8'd10, 8'd4, 8'd1}},
        '{mr: {8'd3, 8'd12, 8'd10, 8'd4, 8'd7, 8'd2, 8'd15},
          dbl: 6'b101010, ex: {8'd7, 8'd13, 8'd6, 8'd5, 8'd5, 8'd3}},
        '{mr: {8'd7, 8'd0, 8'd6, 8'd1, 8'd5, 8'd5, 8'd7},
          dbl: 6'b111111, ex: {8'd7, 8'd2, 8'd5, 8'd4, 8'd0, 8'd6}},
        '{mr: {8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0},
          dbl: 6'b000100, ex: {8'd1, 8'd1, 8'd1, 8'd0, 8'd1, 8'd1}}
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output int v);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic count_hi(input int ncyc, output int c [6]);
        for (int i = 0; i < 6; i++) c[i] = 0;
        for (int k = 0; k < ncyc; k++) begin
            @(negedge clk);
            for (int i = 0; i < 6; i++) if (pwm_o[i]) c[i]++;
        end
    endtask

    task automatic setup(input logic [6:0][7:0] mr, input logic [5:0] dbl,
                         input int presc, input int mact);
        wr(A_CTRL, 32'h2);
        wr(A_PRESC, presc);
        wr(A_MACT, mact);
        for (int m = 0; m < 7; m++) wr(4'(A_MATCH0 + m), 32'(mr[m]));
        wr(A_LATCH, 32'h7F);
        wr(A_MODE, 32'(dbl));
        wr(A_OEN, 32'h3F);
        wr(A_CTRL, 32'h1);
    endtask

    initial begin
        int v;
        int c [6];
        int mx;

        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 pwm_o", int'(pwm_o), 0);
        chk("R10 irq_o", int'(irq_o), 0);
        rd(A_COUNT, v); chk("R10 count", v, 0);
        rd(A_CTRL, v);  chk("R10 ctrl", v, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 pwm_o after release", int'(pwm_o), 0);

        // vector table: duty of every output over one period
        for (int t = 0; t < 4; t++) begin
            setup(VECS[t].mr, VECS[t].dbl, 0, 32'h2);
            repeat (64) @(negedge clk);
            count_hi(int'(VECS[t].mr[0]) + 1, c);
            for (int i = 0; i < 6; i++) begin
                // R2 R3 R4: period MR0+1, single and double edge duty
                chk($sformatf("R3/R4 vec%0d out%0d", t, i + 1), c[i], int'(VECS[t].ex[i]));
            end
        end

        // R5: shadow readback
        rd(4'(A_MATCH0 + 2), v); chk("R5 shadow readback", v, 0);

        // single-edge base: MR0=9, MR1=0
        setup({8'd9, 8'd9, 8'd9, 8'd9, 8'd9, 8'd0, 8'd9}, 6'b0, 0, 32'h2);
        repeat (30) @(negedge clk);
        // R2: counter never exceeds MR0
        mx = 0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            rd(A_COUNT, v);
            if (v > mx) mx = v;
        end
        chk("R2 count max", mx, 9);

        // R5: unlatched shadow change has no effect
        wr(4'(A_MATCH0 + 1), 32'd4);
        rd(4'(A_MATCH0 + 1), v); chk("R5 shadow value", v, 4);
        repeat (30) @(negedge clk);
        count_hi(10, c); chk("R5 unlatched out1", c[0], 1);
        wr(A_LATCH, 32'h2);
        repeat (30) @(negedge clk);
        count_hi(10, c); chk("R5 latched out1", c[0], 5);
        rd(A_LATCH, v); chk("R5 pending cleared", v, 0);

        // R8: disabled output stays low
        wr(A_OEN, 32'h3E);
        count_hi(20, c); chk("R8 out1 disabled", c[0], 0);
        chk("R8 out2 still full", c[1], 20);
        wr(A_OEN, 32'h3F);

        // R6: interrupt flag on match 0
        chk("R6 irq idle", int'(irq_o), 0);
        wr(A_MACT, 32'h3);
        repeat (25) @(negedge clk);
        rd(A_FLAGS, v); chk("R6 flag set", v, 1);
        chk("R6 irq high", int'(irq_o), 1);
        wr(A_MACT, 32'h2);
        wr(A_FLAGS, 32'h1);
        rd(A_FLAGS, v); chk("R6 flag cleared", v, 0);
        chk("R6 irq low", int'(irq_o), 0);

        // R9: hold keeps counter at zero, single-edge high
        wr(A_CTRL, 32'h3);
        repeat (5) @(negedge clk);
        rd(A_COUNT, v); chk("R9 count held", v, 0);
        chk("R9 out1 high", int'(pwm_o[0]), 1);

        // R1: prescaler PRESC=3, MR0=4, MR1=1 -> 8 high of 20 clocks
        setup({8'd9, 8'd9, 8'd9, 8'd9, 8'd9, 8'd1, 8'd4}, 6'b0, 3, 32'h2);
        repeat (100) @(negedge clk);
        count_hi(20, c); chk("R1 prescaled out1", c[0], 8);

        // R7: stop on match 2 (MR2=6), reset on match 0
        setup({8'd9, 8'd9, 8'd9, 8'd9, 8'd6, 8'd0, 8'd9}, 6'b0, 0, 32'h102);
        repeat (40) @(negedge clk);
        rd(A_COUNT, v); chk("R7 stopped count", v, 6);
        rd(A_CTRL, v);  chk("R7 run cleared", v, 0);
        repeat (10) @(negedge clk);
        rd(A_COUNT, v); chk("R7 count still", v, 6);
        // R5: no boundary while stopped, latch stays pending
        wr(A_MATCH0, 32'd5);
        wr(A_LATCH, 32'h1);
        repeat (5) @(negedge clk);
        rd(A_LATCH, v); chk("R5 pending kept", v, 1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule